// File: doc/BRIEF.md
# Serial Transmitter with Programmable Bit Clock

This block turns bytes into asynchronous serial characters on a single output line. A bit clock is derived from the system clock through an optional fixed divide-by-8 stage, a programmable generator count and a programmable divisor count. Each character has a low start bit, then 6, 7 or 8 data bits sent least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. The format is taken from a mode register. A control register gates the transmitter, carries one-shot reset commands and drives a break.

Bytes arrive on a valid/ready handshake into a single holding slot. The slot is copied into a shift register as soon as the line is free, which lets the next byte be offered while the current character is still going out. Three status outputs report the state of the block: holding slot empty, holding slot full, and character in progress. Storage deeper than one byte, the receive path and register address decode belong to neighbouring blocks.

Top module: `sertx_top`

## Requirements
- R1: One bit lasts PRE × G × (D + 1) clock cycles, where G is the generator value, D is the divisor value, and PRE is 8 when mode bit 0 is 1 and 1 when it is 0.
- R2: Mode bits [2:1] give the data length: 2'b11 selects 6 bits, 2'b10 selects 7 bits, and any other value selects 8 bits.
- R3: Mode bits [5:3] select parity: 3'b000 gives even parity (data plus parity has an even number of ones), 3'b001 gives odd parity, and any other value gives no parity bit. The parity bit follows the last data bit.
- R4: Mode bits [7:6] equal to 2'b11 give one stop bit. Any other value gives two stop bits.
- R5: The transmitter is on only when control bit 4 is 1 and control bit 5 is 0. While it is off, in_ready is 0 and no new character starts.
- R6: Control bits 0 and 1 act only on the write that sets them and always read back as 0. All other control bits read back as written.
- R7: While control bit 7 is 1 and control bit 8 is 0, txd is held low and no new character starts. A byte that is offered is kept until the break ends.
- R8: After reset the control register reads 9'h128, the mode and divisor values are 0, the generator value is 15, txd is 1, st_empty is 1, and st_full and st_active are 0.
- R9: A control write with bit 1 set aborts the character in progress and drops the held byte. On the next cycle st_empty is 1, st_full is 0, st_active is 0 and txd is 1.
- R10: A character is a 0 start bit, then the data bits least significant first, then parity and stop bits at 1. The line is 1 when idle.
- R11: While the generator value is 0 no character starts, and a held byte stays held.
- R12: st_full is 1 while the holding slot has a byte and st_empty is its inverse. st_active is 1 from the cycle a character is loaded until its last stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 9 | Control write value |
| ctl_rdata | output | 9 | Control register read-back |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode write value (prescale, length, parity, stop) |
| gen_wr | input | 1 | Generator value write strobe |
| gen_wdata | input | GEN_W | Generator value |
| div_wr | input | 1 | Divisor value write strobe |
| div_wdata | input | DIV_W | Divisor value |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to transmit |
| in_ready | output | 1 | Holding slot can take a byte |
| txd | output | 1 | Serial line |
| st_empty | output | 1 | Holding slot empty |
| st_full | output | 1 | Holding slot occupied |
| st_active | output | 1 | Character in progress |

## Verification
The hardest state to reach is a character cut off mid-frame while a second byte waits in the holding slot. A stalled frame cannot be seen from the line unless the bit time is very long. The stimulus sets a generator value of 1000, so the first character is still in progress when a second byte fills the slot, and then issues the one-shot transmit reset. A break with a pending byte, and a zero generator value with a pending byte, are reached the same way. In both cases the bench then releases the condition and checks that the retained byte still leaves with the correct framing.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = 12;   // start + 8 data + parity + 2 stop
    localparam int LEN_W   = 4;
    localparam int CTL_W   = 9;
    localparam int MODE_W  = 8;

    // control register bit positions
    localparam int CB_RXRST  = 0;
    localparam int CB_TXRST  = 1;
    localparam int CB_TXON   = 4;
    localparam int CB_TXOFF  = 5;
    localparam int CB_BRKON  = 7;
    localparam int CB_BRKOFF = 8;

    localparam logic [CTL_W-1:0] CTL_RESET = 9'h128;
    localparam logic [CTL_W-1:0] CTL_ONESHOT_MASK =
        CTL_W'((1 << CB_TXRST) | (1 << CB_RXRST));

    typedef struct packed {
        logic [LEN_W-1:0] data_len;
        logic             par_on;
        logic             par_odd;
        logic             two_stop;
        logic             presc;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    function automatic fmt_t decode_mode(input logic [MODE_W-1:0] m);
        fmt_t f;
        f.presc = m[0];
        case (m[2:1])
            2'b11:   f.data_len = LEN_W'(6);
            2'b10:   f.data_len = LEN_W'(7);
            default: f.data_len = LEN_W'(8);
        endcase
        f.par_on   = (m[5:4] == 2'b00);
        f.par_odd  = m[3];
        f.two_stop = (m[7:6] != 2'b11);
        return f;
    endfunction

    function automatic frame_t build_frame(input logic [DATA_W-1:0] d,
                                           input fmt_t f);
        frame_t fr;
        logic   p;
        int     pidx;
        fr.bits    = '1;
        fr.bits[0] = 1'b0;
        p          = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(f.data_len)) begin
                fr.bits[1+i] = d[i];
                p = p ^ d[i];
            end
        end
        pidx = 1 + int'(f.data_len);
        if (f.par_on) fr.bits[pidx] = p ^ f.par_odd;
        fr.len = LEN_W'(1 + int'(f.data_len) + (f.par_on ? 1 : 0)
                        + (f.two_stop ? 2 : 1));
        return fr;
    endfunction

endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
    import sertx_pkg::*;
#(
    parameter int GEN_W   = 16,
    parameter int DIV_W   = 8,
    parameter int GEN_RST = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_wr,
    input  logic [CTL_W-1:0]    ctl_wdata,
    input  logic                mode_wr,
    input  logic [MODE_W-1:0]   mode_wdata,
    input  logic                gen_wr,
    input  logic [GEN_W-1:0]    gen_wdata,
    input  logic                div_wr,
    input  logic [DIV_W-1:0]    div_wdata,
    output logic [CTL_W-1:0]    ctl_q,
    output fmt_t                fmt,
    output logic [GEN_W-1:0]    gen_q,
    output logic [DIV_W-1:0]    div_q,
    output logic                tx_on,
    output logic                brk,
    output logic                tx_flush
);

    logic [MODE_W-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= CTL_RESET;
            mode_q <= '0;
            gen_q  <= GEN_W'(GEN_RST);
            div_q  <= '0;
        end else begin
            if (ctl_wr)  ctl_q  <= ctl_wdata & ~CTL_ONESHOT_MASK;
            if (mode_wr) mode_q <= mode_wdata;
            if (gen_wr)  gen_q  <= gen_wdata;
            if (div_wr)  div_q  <= div_wdata;
        end
    end

    assign fmt      = decode_mode(mode_q);
    assign tx_on    = ctl_q[CB_TXON] & ~ctl_q[CB_TXOFF];
    assign brk      = ctl_q[CB_BRKON] & ~ctl_q[CB_BRKOFF];
    assign tx_flush = ctl_wr & ctl_wdata[CB_TXRST];

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int GEN_W   = 16,
    parameter int DIV_W   = 8,
    parameter int PRE_DIV = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             presc,
    input  logic [GEN_W-1:0] gen,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [GEN_W-1:0] gen_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_ev;
    logic             gen_ev;

    generate
        if (PRE_DIV > 1) begin : g_pre
            assign pre_ev = ~presc | (pre_cnt == PRE_W'(PRE_DIV - 1));
        end else begin : g_nopre
            assign pre_ev = 1'b1;
        end
    endgenerate

    assign gen_ev = pre_ev & (gen != '0) & (gen_cnt == gen - GEN_W'(1));
    assign tick   = gen_ev & (div_cnt == div);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_cnt <= '0;
            gen_cnt <= '0;
            div_cnt <= '0;
        end else begin
            if (presc && !pre_ev) pre_cnt <= pre_cnt + PRE_W'(1);
            else                  pre_cnt <= '0;
            if (pre_ev) gen_cnt <= gen_ev ? '0 : gen_cnt + GEN_W'(1);
            if (gen_ev) div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  logic   load,
    input  frame_t frame,
    input  logic   tick,
    output logic   busy,
    output logic   line
);

    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   remain;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            shreg  <= '1;
            remain <= '0;
            busy   <= 1'b0;
        end else if (load && !busy) begin
            shreg  <= frame.bits;
            remain <= frame.len;
            busy   <= 1'b1;
        end else if (busy && tick) begin
            shreg  <= {1'b1, shreg[FRAME_W-1:1]};
            remain <= remain - LEN_W'(1);
            if (remain == LEN_W'(1)) busy <= 1'b0;
        end
    end

    assign line = busy ? shreg[0] : 1'b1;

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int GEN_W   = 16,
    parameter int DIV_W   = 8,
    parameter int GEN_RST = 15,
    parameter int PRE_DIV = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [8:0]        ctl_wdata,
    output logic [8:0]        ctl_rdata,
    input  logic              mode_wr,
    input  logic [7:0]        mode_wdata,
    input  logic              gen_wr,
    input  logic [GEN_W-1:0]  gen_wdata,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              txd,
    output logic              st_empty,
    output logic              st_full,
    output logic              st_active
);

    fmt_t               fmt;
    logic [GEN_W-1:0]   gen_q;
    logic [DIV_W-1:0]   div_q;
    logic               tx_on;
    logic               brk;
    logic               tx_flush;
    logic               tick;
    logic               busy;
    logic               line;
    logic               hold_full;
    logic [DATA_W-1:0]  hold_data;
    logic               accept;
    logic               start;
    frame_t             frame;

    sertx_regs #(.GEN_W(GEN_W), .DIV_W(DIV_W), .GEN_RST(GEN_RST)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .gen_wr     (gen_wr),
        .gen_wdata  (gen_wdata),
        .div_wr     (div_wr),
        .div_wdata  (div_wdata),
        .ctl_q      (ctl_rdata),
        .fmt        (fmt),
        .gen_q      (gen_q),
        .div_q      (div_q),
        .tx_on      (tx_on),
        .brk        (brk),
        .tx_flush   (tx_flush)
    );

    assign in_ready = tx_on & ~hold_full;
    assign accept   = in_valid & in_ready & ~tx_flush;
    assign start    = hold_full & ~busy & tx_on & ~brk & (gen_q != '0);
    assign frame    = build_frame(hold_data, fmt);

    always_ff @(posedge clk) begin
        if (rst || tx_flush) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (start) begin
            hold_full <= 1'b0;
        end else if (accept) begin
            hold_full <= 1'b1;
            hold_data <= in_data;
        end
    end

    sertx_baud #(.GEN_W(GEN_W), .DIV_W(DIV_W), .PRE_DIV(PRE_DIV)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .restart (start | tx_flush),
        .presc   (fmt.presc),
        .gen     (gen_q),
        .div     (div_q),
        .tick    (tick)
    );

    sertx_shift u_shift (
        .clk   (clk),
        .rst   (rst),
        .flush (tx_flush),
        .load  (start),
        .frame (frame),
        .tick  (tick),
        .busy  (busy),
        .line  (line)
    );

    assign txd       = brk ? 1'b0 : line;
    assign st_full   = hold_full;
    assign st_empty  = ~hold_full;
    assign st_active = busy;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int GEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_wr,
    input logic [8:0]       ctl_wdata,
    input logic [8:0]       ctl_rdata,
    input logic             in_ready,
    input logic             txd,
    input logic             st_empty,
    input logic             st_full,
    input logic             st_active,
    input logic [GEN_W-1:0] gen_q
);

    AST_ONESHOT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (ctl_rdata[1:0] == 2'b00)); // R6

    AST_READY_GATED: assert property (@(posedge clk) disable iff (rst)
        !(ctl_rdata[4] && !ctl_rdata[5]) |-> !in_ready); // R5

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[7] && !ctl_rdata[8]) |-> !txd); // R7

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!st_active && !(ctl_rdata[7] && !ctl_rdata[8])) |-> txd); // R10

    AST_FLUSH_STATUS: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_wdata[1]) |=> (st_empty && !st_full && !st_active)); // R9

    AST_ZERO_GEN_STALL: assert property (@(posedge clk) disable iff (rst)
        ((gen_q == '0) && !st_active) |=> !st_active); // R11

endmodule

bind sertx_top sertx_chk #(.GEN_W(GEN_W)) u_chk (.*);

// File: tb/sertx_top_bench.sv
module sertx_top_bench;

    localparam int GEN_W = 16;
    localparam int DIV_W = 8;

    typedef struct packed {
        logic [7:0]  mode;
        logic [15:0] gen;
        logic [7:0]  dv;
        logic [7:0]  data;
        logic [3:0]  dbits;
        logic [1:0]  par;      // 0 none, 1 even, 2 odd
        logic [1:0]  stops;
        logic [15:0] period;
    } vec_t;

    // R1 R2 R3 R4: format and bit-time table
    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'hC0, 16'd4, 8'd0, 8'hA5, 4'd8, 2'd1, 2'd1, 16'd4},
        '{8'hCE, 16'd5, 8'd1, 8'h3C, 4'd6, 2'd2, 2'd1, 16'd10},
        '{8'h24, 16'd3, 8'd2, 8'h5B, 4'd7, 2'd0, 2'd2, 16'd9},
        '{8'hD1, 16'd2, 8'd0, 8'h81, 4'd8, 2'd0, 2'd1, 16'd16},
        '{8'h00, 16'd4, 8'd0, 8'hFF, 4'd8, 2'd1, 2'd2, 16'd4},
        '{8'h08, 16'd6, 8'd0, 8'h00, 4'd8, 2'd2, 2'd2, 16'd6}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ctl_wr = 1'b0;
    logic [8:0]       ctl_wdata = '0;
    logic [8:0]       ctl_rdata;
    logic             mode_wr = 1'b0;
    logic [7:0]       mode_wdata = '0;
    logic             gen_wr = 1'b0;
    logic [GEN_W-1:0] gen_wdata = '0;
    logic             div_wr = 1'b0;
    logic [DIV_W-1:0] div_wdata = '0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = '0;
    logic             in_ready;
    logic             txd;
    logic             st_empty;
    logic             st_full;
    logic             st_active;

    int total = 0;
    int bad = 0;
    int act_cnt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    always @(negedge clk) if (st_active) act_cnt <= act_cnt + 1;

    sertx_top #(.GEN_W(GEN_W), .DIV_W(DIV_W)) u_sertx_top (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .gen_wr(gen_wr), .gen_wdata(gen_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .txd(txd), .st_empty(st_empty), .st_full(st_full), .st_active(st_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [8:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic set_fmt(input logic [7:0] m, input logic [15:0] g, input logic [7:0] d);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = m;
        gen_wr = 1'b1; gen_wdata = g;
        div_wr = 1'b1; div_wdata = d;
        @(negedge clk);
        mode_wr = 1'b0; gen_wr = 1'b0; div_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        int guard;
        @(negedge clk); in_valid = 1'b1; in_data = d;
        guard = 0;
        while (!in_ready && guard < 5000) begin @(negedge clk); guard++; end
        @(negedge clk); in_valid = 1'b0;
    endtask

    // expected line levels from the requirements: start, data LSB first, parity, stops
    task automatic capture(input logic [7:0] d, input int dbits, input int par,
                           input int stops, input int period, input string tag);
        logic [15:0] ex;
        int n, p, base, guard;
        ex = '1; ex[0] = 1'b0; p = 0;
        for (int i = 0; i < dbits; i++) begin ex[1+i] = d[i]; p = p ^ int'(d[i]); end
        n = 1 + dbits;
        if (par != 0) begin ex[n] = (par == 2) ? ~p[0] : p[0]; n++; end
        n = n + stops;
        guard = 0;
        while (!txd && guard < 5000) begin @(negedge clk); guard++; end
        base = act_cnt;
        guard = 0;
        while (txd && guard < 5000) begin @(negedge clk); guard++; end
        repeat (period / 2) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            chk(txd == ex[k], $sformatf("R10/R2/R3 %s bit %0d", tag, k), int'(txd), int'(ex[k]));
            if (k < n - 1) repeat (period) @(negedge clk);
        end
        guard = 0;
        while (st_active && guard < 5000) begin @(negedge clk); guard++; end
        // R1 R4: whole character length in cycles
        chk(act_cnt - base == n * period, $sformatf("R1/R4 %s frame cycles", tag),
            act_cnt - base, n * period);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk(ctl_rdata == 9'h128, "R8 control reset", int'(ctl_rdata), 'h128);
        chk(txd == 1'b1, "R8 line idle", int'(txd), 1);
        chk(st_empty && !st_full && !st_active, "R8 status", {st_empty, st_full, st_active}, 3'b100);
        chk(in_ready == 1'b0, "R5 not ready while off", int'(in_ready), 0);

        // R6 one-shot bits read zero
        wr_ctl(9'h113);
        chk(ctl_rdata == 9'h110, "R6 one-shot readback", int'(ctl_rdata), 'h110);
        chk(in_ready == 1'b1, "R5 ready when on", int'(in_ready), 1);

        for (int v = 0; v < NVEC; v++) begin
            set_fmt(VECS[v].mode, VECS[v].gen, VECS[v].dv);
            push(VECS[v].data);
            capture(VECS[v].data, int'(VECS[v].dbits), int'(VECS[v].par),
                    int'(VECS[v].stops), int'(VECS[v].period), $sformatf("vec%0d", v));
        end

        // R5 disable dominates enable
        wr_ctl(9'h130);
        chk(in_ready == 1'b0, "R5 disable dominant", int'(in_ready), 0);
        @(negedge clk); in_valid = 1'b1; in_data = 8'h55;
        repeat (40) @(negedge clk);
        chk(!st_active && txd && st_empty, "R5 no character while off",
            {st_active, txd, st_empty}, 3'b011);
        in_valid = 1'b0;

        // R7 break holds line low, byte waits
        set_fmt(8'hC0, 16'd4, 8'd0);
        wr_ctl(9'h090);
        chk(txd == 1'b0, "R7 break low", int'(txd), 0);
        push(8'h6D);
        repeat (40) @(negedge clk);
        chk(!st_active && st_full && !txd, "R7 no start in break",
            {st_active, st_full, txd}, 3'b010);
        wr_ctl(9'h110);
        capture(8'h6D, 8, 1, 1, 4, "R7 after break");

        // R12 / R9 full slot behind long character, then flush
        set_fmt(8'hC0, 16'd1000, 8'd0);
        push(8'hA1);
        repeat (3) @(negedge clk);
        push(8'hB2);
        repeat (3) @(negedge clk);
        chk(st_active && st_full && !st_empty, "R12 slot full while shifting",
            {st_active, st_full, st_empty}, 3'b110);
        wr_ctl(9'h112);
        chk(st_empty && !st_full && !st_active && txd, "R9 flush status",
            {st_empty, st_full, st_active, txd}, 4'b1001);
        chk(ctl_rdata == 9'h110, "R6 flush bit reads zero", int'(ctl_rdata), 'h110);

        // R11 zero generator stalls, byte kept
        set_fmt(8'hC0, 16'd0, 8'd0);
        push(8'h4E);
        repeat (200) @(negedge clk);
        chk(!st_active && txd && st_full, "R11 no start at zero generator",
            {st_active, txd, st_full}, 3'b011);
        set_fmt(8'hC0, 16'd4, 8'd0);
        capture(8'h4E, 8, 1, 1, 4, "R11 released");
        chk(st_empty && !st_full, "R12 slot empty after send", {st_empty, st_full}, 2'b10);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule